// File: doc/BRIEF.md
# Block Transfer Sequencer

This block sequences multi-word register transfers for a small processor core. One command covers four kinds of transfer: a load of several registers from memory, a store of several registers to memory, a push onto a full-descending stack, and a pop from that stack. A command carries a base address, an eight-bit mask of low registers and a flag for one extra slot. On a push the extra slot is the link register. On a pop it is the program counter. A writeback enable comes with the command as well. The block then issues one word request per selected register, lowest register number first, at rising word addresses.

The sequencer does not hold register contents and does not contain memory. For each beat it names the register it is working on. Store data is read back from the register file through that name. Load data goes out to the register file on a write strobe. When the command finishes, the block gives the updated base for writeback. On a pop that includes the program counter, it also raises a redirect indication that carries the loaded target. A command whose register list is empty is refused with an error pulse.

Top module: `blkxfer_seq`

## Requirements
- R1: Beats go out in ascending register order, with the extra slot (if any) last. The first beat uses the start address and each later beat uses the previous address plus 4. For a load-multiple, store-multiple or pop, the start address is the base.
- R2: For a load-multiple or store-multiple with writeback enabled, `wb_valid` rises together with `done` and `wb_value` equals base plus 4 times the beat count. With writeback disabled, `wb_valid` stays low. Push and pop always write back.
- R3: A push starts at base minus 4 times the beat count and stores the link register (index 14) after the listed low registers. Its writeback value is that start address. Every store beat drives `mem_we` high and passes `st_data` to `mem_wdata`.
- R4: A pop with the extra flag loads the program counter (index 15) as its last beat and writes back base plus 4 times the count. `pc_load` rises together with `done`, and `pc_value` is the loaded word with bit 0 cleared. The program-counter beat raises no `ld_we`.
- R5: The extra flag has no effect on load-multiple and store-multiple: no extra beat is added and the count ignores the flag.
- R6: A command whose beat count is zero causes a one-cycle `err` pulse in the cycle after it is accepted. It issues no memory request and no `done`. A push with only the link register is not empty.
- R7: A beat completes only in a cycle where `mem_req` and `mem_ready` are both high. While `mem_ready` is low, `mem_addr`, `mem_we` and `reg_idx` hold steady.
- R8: `done` is high for exactly one cycle, the cycle after the final beat. `busy` is high from the cycle after acceptance through the `done` cycle. A `start` seen while busy, including during the `done` cycle, is ignored. After reset, `busy`, `mem_req`, `done` and `err` are low.
- R9: Each accepted load beat of a non-program-counter register raises `ld_we` in that same cycle, with `ld_idx` equal to `reg_idx` and `ld_data` equal to `mem_rdata`.
- R10: `cmd_kind` encodes 0 load-multiple, 1 store-multiple, 2 push, 3 pop. Kinds 1 and 2 write memory; kinds 0 and 3 read it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, accepted when not busy |
| cmd_kind | input | 2 | Transfer kind (R10 encoding) |
| base_in | input | AW | Base register or stack pointer value |
| reg_list | input | NLIST | Low-register selection mask |
| extra_en | input | 1 | Add link register (push) or program counter (pop) slot |
| wb_en | input | 1 | Writeback request for load/store-multiple |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Word address of the current beat |
| mem_wdata | output | AW | Store data of the current beat |
| mem_rdata | input | AW | Load data returned for the current beat |
| mem_ready | input | 1 | Memory accepts/completes the current beat |
| reg_idx | output | 4 | Register number of the current beat |
| st_data | input | AW | Register file read data for `reg_idx` |
| ld_we | output | 1 | Register file write strobe |
| ld_idx | output | 4 | Register file write index |
| ld_data | output | AW | Register file write data |
| done | output | 1 | Command finished (one cycle) |
| err | output | 1 | Empty command refused (one cycle) |
| wb_valid | output | 1 | Base writeback valid (with done) |
| wb_value | output | AW | Updated base value |
| pc_load | output | 1 | Program-counter redirect (with done) |
| pc_value | output | AW | Redirect target, bit 0 cleared |

## Verification
One collision is a new `start` that arrives while the previous command is still running, and especially in its `done` cycle. In that cycle the controller is leaving the final state and the bench's stimulus would like a fresh acceptance. The bench holds `start` high from the first cycle through the `done` cycle of a load-multiple. It then checks that exactly the expected beats and a single `done` occur, and that no request follows. A second collision happens on a pop that ends with the program counter: the redirect, the stack writeback and `done` all fall in one cycle. The bench checks all three values together in that cycle.

// File: rtl/blkxfer_pkg.sv
`timescale 1ns/1ps
package blkxfer_pkg;

    typedef enum logic [1:0] {
        XK_LOADM  = 2'd0,
        XK_STOREM = 2'd1,
        XK_PUSH   = 2'd2,
        XK_POP    = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } seq_state_e;

    localparam int          IDX_W    = 4;
    localparam logic [3:0]  LINK_IDX = 4'd14;
    localparam logic [3:0]  PROG_IDX = 4'd15;

    typedef struct packed {
        xfer_kind_e kind;
        logic       extra;
        logic       want_wb;
        logic       pc_hit;
    } xfer_ctx_t;

    function automatic logic kind_is_load(input xfer_kind_e k);
        return (k == XK_LOADM) || (k == XK_POP);
    endfunction

    function automatic logic kind_is_stack(input xfer_kind_e k);
        return (k == XK_PUSH) || (k == XK_POP);
    endfunction

endpackage

// File: rtl/blkxfer_pick.sv
`timescale 1ns/1ps
module blkxfer_pick
    import blkxfer_pkg::*;
#(
    parameter int NLIST = 8
) (
    input  logic [NLIST-1:0] mask,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [NLIST-1:0] mask_nxt
);
    logic [NLIST:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar g = 0; g < NLIST; g++) begin : g_scan
            assign seen[g+1] = seen[g] | mask[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = NLIST - 1; i >= 0; i--) begin
            if (mask[i] && !seen[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any      = seen[NLIST];
    assign mask_nxt = mask & (mask - NLIST'(1));

endmodule

// File: rtl/blkxfer_plan.sv
`timescale 1ns/1ps
module blkxfer_plan
    import blkxfer_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NLIST = 8
) (
    input  xfer_kind_e       kind,
    input  logic [AW-1:0]    base,
    input  logic [NLIST-1:0] list,
    input  logic             extra_req,
    output logic             extra_eff,
    output logic             empty,
    output logic [AW-1:0]    first_addr,
    output logic [AW-1:0]    final_base
);
    localparam int CW = $clog2(NLIST + 2);

    logic [CW-1:0] psum [NLIST+1];
    logic [CW-1:0] count;
    logic [AW-1:0] span;

    assign psum[0] = '0;

    generate
        for (genvar g = 0; g < NLIST; g++) begin : g_cnt
            assign psum[g+1] = psum[g] + CW'(list[g]);
        end
    endgenerate

    assign extra_eff = extra_req && kind_is_stack(kind);
    assign count     = psum[NLIST] + CW'(extra_eff);
    assign empty     = (count == '0);
    assign span      = {{(AW-CW-2){1'b0}}, count, 2'b00};

    always_comb begin
        if (kind == XK_PUSH) begin
            first_addr = base - span;
            final_base = base - span;
        end else begin
            first_addr = base;
            final_base = base + span;
        end
    end

endmodule

// File: rtl/blkxfer_ctrl.sv
`timescale 1ns/1ps
module blkxfer_ctrl
    import blkxfer_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NLIST = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  xfer_kind_e       kind_in,
    input  logic [NLIST-1:0] list_in,
    input  logic             extra_in,
    input  logic             wb_in,
    input  logic [AW-1:0]    first_addr,
    input  logic [AW-1:0]    final_base,
    input  logic             empty,
    output logic [NLIST-1:0] mask_cur,
    input  logic             pick_any,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic [NLIST-1:0] pick_nxt,
    input  logic             mem_ready,
    input  logic [AW-1:0]    mem_rdata,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [IDX_W-1:0] reg_idx,
    output logic             ld_we,
    output logic [IDX_W-1:0] ld_idx,
    output logic [AW-1:0]    ld_data,
    output logic             done,
    output logic             err,
    output logic             wb_valid,
    output logic [AW-1:0]    wb_value,
    output logic             pc_load,
    output logic [AW-1:0]    pc_value
);
    seq_state_e       st;
    xfer_ctx_t        ctx;
    logic [NLIST-1:0] mask_q;
    logic [AW-1:0]    addr_q;
    logic [AW-1:0]    wb_q;
    logic [AW-1:0]    pc_q;
    logic             err_q;

    logic on_extra;
    logic last_beat;
    logic beat;

    always_comb begin
        on_extra  = !pick_any;
        last_beat = on_extra || ((pick_nxt == '0) && !ctx.extra);
        beat      = (st == SQ_RUN) && mem_ready;
        if (on_extra) begin
            reg_idx = (ctx.kind == XK_POP) ? PROG_IDX : LINK_IDX;
        end else begin
            reg_idx = pick_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            ctx    <= '0;
            mask_q <= '0;
            addr_q <= '0;
            wb_q   <= '0;
            pc_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        ctx.kind    <= kind_in;
                        ctx.extra   <= extra_in;
                        ctx.want_wb <= kind_is_stack(kind_in) || wb_in;
                        ctx.pc_hit  <= (kind_in == XK_POP) && extra_in;
                        mask_q      <= list_in;
                        addr_q      <= first_addr;
                        wb_q        <= final_base;
                        if (empty) begin
                            err_q <= 1'b1;
                        end else begin
                            st <= SQ_RUN;
                        end
                    end
                end
                SQ_RUN: begin
                    if (beat) begin
                        addr_q <= addr_q + AW'(4);
                        if (on_extra) begin
                            ctx.extra <= 1'b0;
                            if (ctx.kind == XK_POP) begin
                                pc_q <= {mem_rdata[AW-1:1], 1'b0};
                            end
                        end else begin
                            mask_q <= pick_nxt;
                        end
                        if (last_beat) begin
                            st <= SQ_FIN;
                        end
                    end
                end
                SQ_FIN: begin
                    st <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign mask_cur = mask_q;
    assign busy     = (st != SQ_IDLE);
    assign mem_req  = (st == SQ_RUN);
    assign mem_we   = mem_req && !kind_is_load(ctx.kind);
    assign mem_addr = addr_q;
    assign ld_we    = beat && kind_is_load(ctx.kind) && !on_extra;
    assign ld_idx   = reg_idx;
    assign ld_data  = mem_rdata;
    assign done     = (st == SQ_FIN);
    assign err      = err_q;
    assign wb_valid = done && ctx.want_wb;
    assign wb_value = wb_q;
    assign pc_load  = done && ctx.pc_hit;
    assign pc_value = pc_q;

endmodule

// File: rtl/blkxfer_seq.sv
`timescale 1ns/1ps
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NLIST = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       cmd_kind,
    input  logic [AW-1:0]    base_in,
    input  logic [NLIST-1:0] reg_list,
    input  logic             extra_en,
    input  logic             wb_en,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [AW-1:0]    mem_wdata,
    input  logic [AW-1:0]    mem_rdata,
    input  logic             mem_ready,
    output logic [3:0]       reg_idx,
    input  logic [AW-1:0]    st_data,
    output logic             ld_we,
    output logic [3:0]       ld_idx,
    output logic [AW-1:0]    ld_data,
    output logic             done,
    output logic             err,
    output logic             wb_valid,
    output logic [AW-1:0]    wb_value,
    output logic             pc_load,
    output logic [AW-1:0]    pc_value
);
    xfer_kind_e       kind_w;
    logic             extra_eff;
    logic             empty;
    logic [AW-1:0]    first_addr;
    logic [AW-1:0]    final_base;
    logic [NLIST-1:0] mask_cur;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic [NLIST-1:0] pick_nxt;

    assign kind_w    = xfer_kind_e'(cmd_kind);
    assign mem_wdata = st_data;

    blkxfer_plan #(.AW(AW), .NLIST(NLIST)) u_plan (
        .kind       (kind_w),
        .base       (base_in),
        .list       (reg_list),
        .extra_req  (extra_en),
        .extra_eff  (extra_eff),
        .empty      (empty),
        .first_addr (first_addr),
        .final_base (final_base)
    );

    blkxfer_pick #(.NLIST(NLIST)) u_pick (
        .mask     (mask_cur),
        .any      (pick_any),
        .idx      (pick_idx),
        .mask_nxt (pick_nxt)
    );

    blkxfer_ctrl #(.AW(AW), .NLIST(NLIST)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .kind_in    (kind_w),
        .list_in    (reg_list),
        .extra_in   (extra_eff),
        .wb_in      (wb_en),
        .first_addr (first_addr),
        .final_base (final_base),
        .empty      (empty),
        .mask_cur   (mask_cur),
        .pick_any   (pick_any),
        .pick_idx   (pick_idx),
        .pick_nxt   (pick_nxt),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .reg_idx    (reg_idx),
        .ld_we      (ld_we),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .done       (done),
        .err        (err),
        .wb_valid   (wb_valid),
        .wb_value   (wb_value),
        .pc_load    (pc_load),
        .pc_value   (pc_value)
    );

endmodule

// File: rtl/blkxfer_seq_chk.sv
`timescale 1ns/1ps
module blkxfer_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] mem_rdata,
    input logic [3:0]    reg_idx,
    input logic          ld_we,
    input logic [AW-1:0] ld_data,
    input logic          done,
    input logic          err,
    input logic          wb_valid,
    input logic          pc_load,
    input logic [AW-1:0] pc_value
);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(reg_idx) && $stable(mem_we)));

    assert_ascend_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + AW'(4))));

    assert_done_after_beat_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_req && mem_ready));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        err |-> (!mem_req && !done));

    assert_pc_even_R4: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (done && !pc_value[0]));

    assert_ldwe_beat_R9: assert property (@(posedge clk) disable iff (rst)
        ld_we |-> (mem_req && mem_ready && !mem_we && (ld_data == mem_rdata)));

    assert_wb_with_done_R2: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> done);

endmodule

bind blkxfer_seq blkxfer_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .reg_idx   (reg_idx),
    .ld_we     (ld_we),
    .ld_data   (ld_data),
    .done      (done),
    .err       (err),
    .wb_valid  (wb_valid),
    .pc_load   (pc_load),
    .pc_value  (pc_value)
);

// File: tb/blkxfer_seq_test.sv
`timescale 1ns/1ps
module blkxfer_seq_test;
    localparam int AW    = 32;
    localparam int NLIST = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             start = 1'b0;
    logic [1:0]       cmd_kind = 2'd0;
    logic [AW-1:0]    base_in = '0;
    logic [NLIST-1:0] reg_list = '0;
    logic             extra_en = 1'b0;
    logic             wb_en = 1'b0;
    logic             busy, mem_req, mem_we, mem_ready;
    logic [AW-1:0]    mem_addr, mem_wdata, mem_rdata, st_data;
    logic [3:0]       reg_idx, ld_idx;
    logic             ld_we, done, err, wb_valid, pc_load;
    logic [AW-1:0]    ld_data, wb_value, pc_value;

    blkxfer_seq #(.AW(AW), .NLIST(NLIST)) uut (
        .clk(clk), .rst(rst), .start(start), .cmd_kind(cmd_kind),
        .base_in(base_in), .reg_list(reg_list), .extra_en(extra_en), .wb_en(wb_en),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .reg_idx(reg_idx), .st_data(st_data), .ld_we(ld_we), .ld_idx(ld_idx),
        .ld_data(ld_data), .done(done), .err(err), .wb_valid(wb_valid),
        .wb_value(wb_value), .pc_load(pc_load), .pc_value(pc_value)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] mem_model [64];
    assign mem_rdata = mem_model[mem_addr[7:2]];
    assign st_data   = 32'hA5A5_0000 | {28'd0, reg_idx};

    int   cyc = 0;
    int   tick = 0;
    logic stall_en = 1'b0;
    logic rdy_q = 1'b1;
    always @(posedge clk) begin
        cyc   <= cyc + 1;
        tick  <= tick + 1;
        rdy_q <= !stall_en || ((tick % 3) == 2);
    end
    assign mem_ready = rdy_q;

    int          nb, nld, ndone, nerr, nwb, npc, hold_bad;
    int          last_beat_cyc, done_cyc, err_cyc, start_cyc;
    logic [31:0] b_addr [16];
    logic [31:0] b_wd   [16];
    logic [3:0]  b_idx  [16];
    logic        b_we   [16];
    logic [3:0]  l_idx  [16];
    logic [31:0] l_data [16];
    logic [31:0] wb_seen, pc_seen, prev_addr;
    logic        prev_stall;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall && (!mem_req || mem_addr != prev_addr)) hold_bad++;
            prev_stall = mem_req && !mem_ready;
            prev_addr  = mem_addr;
            if (start && !busy) start_cyc = cyc;
            if (mem_req && mem_ready) begin
                if (nb < 16) begin
                    b_addr[nb] = mem_addr;
                    b_idx[nb]  = reg_idx;
                    b_we[nb]   = mem_we;
                    b_wd[nb]   = mem_wdata;
                end
                nb++;
                last_beat_cyc = cyc;
                if (mem_we) mem_model[mem_addr[7:2]] = mem_wdata;
            end
            if (ld_we) begin
                if (nld < 16) begin
                    l_idx[nld]  = ld_idx;
                    l_data[nld] = ld_data;
                end
                nld++;
            end
            if (done) begin ndone++; done_cyc = cyc; end
            if (err) begin nerr++; err_cyc = cyc; end
            if (wb_valid) begin nwb++; wb_seen = wb_value; end
            if (pc_load) begin npc++; pc_seen = pc_value; end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic clear_logs();
        nb = 0; nld = 0; ndone = 0; nerr = 0; nwb = 0; npc = 0; hold_bad = 0;
        last_beat_cyc = -1; done_cyc = -1; err_cyc = -1; start_cyc = -1;
        prev_stall = 1'b0;
        for (int i = 0; i < 64; i++) mem_model[i] = 32'hC0DE_0001 + 32'(i * 4);
    endtask

    task automatic issue(input logic [1:0] kind, input logic [31:0] base, input logic [7:0] list,
                         input logic extra, input logic wb, input logic stall, input logic hold);
        clear_logs();
        stall_en = stall;
        @(posedge clk); #1;
        start = 1'b1; cmd_kind = kind; base_in = base; reg_list = list;
        extra_en = extra; wb_en = wb;
        if (!hold) begin
            @(posedge clk); #1;
            start = 1'b0;
        end else begin
            for (int w = 0; w < 80; w++) begin
                @(posedge clk); #1;
                if (done) begin
                    @(posedge clk); #1;
                    break;
                end
            end
            start = 1'b0;
        end
        for (int w = 0; w < 80; w++) begin
            if (ndone != 0 || nerr != 0) break;
            @(posedge clk); #1;
        end
        repeat (4) @(posedge clk);
        #1;
        stall_en = 1'b0;
    endtask

    task automatic check_run(input logic [1:0] kind, input logic [31:0] base, input logic [7:0] list,
                             input logic extra, input logic wb);
        logic [3:0]  ei [16];
        int          n = 0;
        int          nl;
        logic        stack = kind[1];
        logic        xe = extra && kind[1];
        logic [31:0] first, fin, lastd;
        for (int i = 0; i < 8; i++) if (list[i]) begin ei[n] = 4'(i); n++; end
        if (xe) begin ei[n] = (kind == 2'd3) ? 4'd15 : 4'd14; n++; end
        first = (kind == 2'd2) ? base - 32'(4 * n) : base;
        fin   = (kind == 2'd2) ? first : base + 32'(4 * n);
        chk(nb == n, "R1 beat count", 32'(nb), 32'(n));
        for (int k = 0; k < n && k < nb; k++) begin
            chk(b_addr[k] == first + 32'(4 * k), "R1 beat address", b_addr[k], first + 32'(4 * k));
            chk(b_idx[k] == ei[k], "R1 register order", 32'(b_idx[k]), 32'(ei[k]));
            chk(b_we[k] == (kind == 2'd1 || kind == 2'd2), "R10 direction", 32'(b_we[k]),
                32'(kind == 2'd1 || kind == 2'd2));
            if (b_we[k])
                chk(b_wd[k] == (32'hA5A5_0000 | 32'(ei[k])), "R3 store data", b_wd[k],
                    32'hA5A5_0000 | 32'(ei[k]));
        end
        chk(ndone == 1, "R8 done count", 32'(ndone), 32'd1);
        chk(done_cyc == last_beat_cyc + 1, "R8 done timing", 32'(done_cyc), 32'(last_beat_cyc + 1));
        if (stack || wb)
            chk(nwb == 1 && wb_seen == fin, "R2 writeback value", wb_seen, fin);
        else
            chk(nwb == 0, "R2 no writeback", 32'(nwb), 32'd0);
        nl = (kind == 2'd0 || kind == 2'd3) ? n - ((kind == 2'd3 && xe) ? 1 : 0) : 0;
        chk(nld == nl, "R9 load write count", 32'(nld), 32'(nl));
        for (int k = 0; k < nl && k < nld; k++) begin
            chk(l_data[k] == 32'hC0DE_0001 + {24'd0, b_addr[k][7:0]}, "R9 load data",
                l_data[k], 32'hC0DE_0001 + {24'd0, b_addr[k][7:0]});
            chk(l_idx[k] == ei[k], "R9 load index", 32'(l_idx[k]), 32'(ei[k]));
        end
        if (kind == 2'd3 && xe) begin
            lastd = (32'hC0DE_0001 + {24'd0, b_addr[n-1][7:0]}) & ~32'd1;
            chk(npc == 1 && pc_seen == lastd, "R4 pc redirect value", pc_seen, lastd);
        end else begin
            chk(npc == 0, "R4 no pc redirect", 32'(npc), 32'd0);
        end
        chk(hold_bad == 0, "R7 stall hold", 32'(hold_bad), 32'd0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R8 reset busy", 32'(busy), 32'd0);
        chk(mem_req == 1'b0, "R8 reset mem_req", 32'(mem_req), 32'd0);
        chk(done == 1'b0, "R8 reset done", 32'(done), 32'd0);
        chk(err == 1'b0, "R6 reset err", 32'(err), 32'd0);
    endtask

    task automatic t_loadm();
        issue(2'd0, 32'h40, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b0);
        check_run(2'd0, 32'h40, 8'hA5, 1'b1, 1'b1);
        chk(nb == 4, "R5 no extra slot on load-multiple", 32'(nb), 32'd4);
    endtask

    task automatic t_storem();
        issue(2'd1, 32'h80, 8'h18, 1'b1, 1'b0, 1'b1, 1'b0);
        check_run(2'd1, 32'h80, 8'h18, 1'b1, 1'b0);
        chk(nb == 2, "R5 no extra slot on store-multiple", 32'(nb), 32'd2);
        chk(mem_model[32'h84 >> 2] == 32'hA5A5_0004, "R3 store reached memory",
            mem_model[32'h84 >> 2], 32'hA5A5_0004);
    endtask

    task automatic t_push();
        issue(2'd2, 32'hC0, 8'h03, 1'b1, 1'b0, 1'b1, 1'b0);
        check_run(2'd2, 32'hC0, 8'h03, 1'b1, 1'b0);
        chk(b_idx[2] == 4'd14 && b_addr[2] == 32'hBC, "R3 link register last", b_addr[2], 32'hBC);
        chk(wb_seen == 32'hB4, "R3 push stack pointer", wb_seen, 32'hB4);
    endtask

    task automatic t_push_lr_only();
        issue(2'd2, 32'h60, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(nerr == 0, "R6 link-only push is not empty", 32'(nerr), 32'd0);
        check_run(2'd2, 32'h60, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic t_pop();
        issue(2'd3, 32'h20, 8'h81, 1'b1, 1'b0, 1'b1, 1'b0);
        check_run(2'd3, 32'h20, 8'h81, 1'b1, 1'b0);
        chk(pc_seen == 32'hC0DE_0028, "R4 pc bit0 cleared", pc_seen, 32'hC0DE_0028);
        chk(wb_seen == 32'h2C, "R4 pop stack pointer", wb_seen, 32'h2C);
        chk(done_cyc == last_beat_cyc + 1 && nwb == 1 && npc == 1, "R4 redirect with writeback and done",
            32'(npc), 32'd1);
    endtask

    task automatic t_pop_nopc();
        issue(2'd3, 32'h10, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0);
        check_run(2'd3, 32'h10, 8'h0F, 1'b0, 1'b0);
    endtask

    task automatic t_empty(input logic [1:0] kind, input logic extra);
        issue(kind, 32'h30, 8'h00, extra, 1'b1, 1'b0, 1'b0);
        chk(nerr == 1, "R6 error pulse count", 32'(nerr), 32'd1);
        chk(err_cyc == start_cyc + 1, "R6 error timing", 32'(err_cyc), 32'(start_cyc + 1));
        chk(nb == 0, "R6 no requests", 32'(nb), 32'd0);
        chk(ndone == 0 && nwb == 0, "R6 no done", 32'(ndone), 32'd0);
    endtask

    task automatic t_overlap();
        issue(2'd0, 32'h10, 8'h06, 1'b0, 1'b1, 1'b0, 1'b1);
        check_run(2'd0, 32'h10, 8'h06, 1'b0, 1'b1);
        chk(nb == 2 && ndone == 1, "R8 start during busy ignored", 32'(nb), 32'd2);
        chk(busy == 1'b0 && mem_req == 1'b0, "R8 idle after held start", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_logs();
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        t_reset();
        t_loadm();
        t_storem();
        t_push();
        t_push_lr_only();
        t_pop();
        t_pop_nopc();
        t_empty(2'd0, 1'b1);
        t_empty(2'd2, 1'b0);
        t_overlap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule